// File: doc/BRIEF.md
# USB Suspend and Resume Controller

This block tracks the low-power state of a full-speed USB device and presents it through one 8-bit power/control register. A timebase tick of 1 MHz or slower drives an idle timer. With suspend enabled, the timer counts ticks while the serial interface engine reports an idle bus. After 3 ms of unbroken idle time the block enters suspend and raises its suspend indication. Any bus activity restarts the count from zero. During a bus reset the count is frozen.

Software leaves suspend by reading the common interrupt flag register, which arrives here as a read strobe, or by setting the resume bit. While the resume bit is 1, the block drives resume signaling for remote wakeup. Software decides how long to hold it: at least 1 ms, at most 15 ms, about 10 ms being typical. The register also shows whether bus reset signaling is present. It holds a read/write isochronous zero-length-before-SOF flag. Every field returns to zero when the chip enters a deep power mode.

Top module: `usb_pwr_ctl`

## Requirements
- R1: After reset, read_data is 0x00, resume_drive is 0 and suspended is 0.
- R2: Register layout is: bit 0 suspend enable (read/write), bit 1 suspend status (read-only), bit 2 resume (read/write), bit 3 bus reset status (read-only), bits 6:4 reserved, bit 7 isochronous wait-for-SOF flag (read/write). A write updates only bits 0, 2 and 7. Bits 6:4 always read 0, and writes to bits 1, 3 and 6:4 have no effect.
- R3: Bit 3 of read_data equals the value bus_reset had in the previous clock cycle.
- R4: With suspend enabled, suspended rises in the cycle after the IDLE_US/TICK_US-th consecutive qualifying tick. A qualifying tick is a tick with bus_idle=1 and bus_reset=0. suspended never rises one tick earlier.
- R5: A cycle with bus_idle=0 (and bus_reset=0) restarts the idle count from zero.
- R6: While bus_reset is 1, the idle count neither advances nor restarts.
- R7: Writing suspend enable to 0 discards any pending idle count and clears suspended.
- R8: A cycle with irq_read=1 clears suspended in the next cycle.
- R9: resume_drive equals the resume bit. Setting the resume bit clears suspended, and suspended stays 0 while the resume bit is 1.
- R10: power_down=1 returns every field to 0 in the next cycle and clears the idle count, overriding a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse, TICK_US microseconds apart |
| bus_idle | input | 1 | 1 when the bus shows no activity |
| bus_reset | input | 1 | 1 while bus reset signaling is detected |
| power_down | input | 1 | Chip is entering a deep power mode |
| wr_en | input | 1 | Write strobe for the power/control register |
| wr_data | input | 8 | Write data |
| irq_read | input | 1 | Read strobe of the common interrupt flag register |
| read_data | output | 8 | Power/control register value |
| resume_drive | output | 1 | Enable for resume signaling to the transceiver logic |
| suspended | output | 1 | Suspend indication |

## Verification
The bench runs the idle threshold at a small scaled value. It checks that suspend rises on exactly the last tick, so an off-by-one timer would enter suspend one tick early or late. A single active cycle just before the threshold must restart the count; a design that only paused would suspend too soon. A bus reset in the middle of an idle stretch must freeze the count; a design that cleared it would suspend late, and one that kept counting would suspend early. Clearing enable, reading the interrupt register, setting resume and a power-down during a write must each leave suspend cleared, and the power-down must also wipe the register; a design with the wrong priority would keep stale state.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_EN   = 0;
  localparam int BIT_SUSP = 1;
  localparam int BIT_RES  = 2;
  localparam int BIT_RST  = 3;
  localparam int BIT_ISO  = 7;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int IDLE_TICKS = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  logic en,
  input  logic bus_idle,
  input  logic bus_reset,
  input  logic hold,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(IDLE_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(IDLE_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    done  = 1'b0;
    if (clr_all || !en) begin
      cnt_n = '0;
    end else if (bus_reset) begin
      cnt_n = cnt_q;
    end else if (!bus_idle) begin
      cnt_n = '0;
    end else if (tick && !hold) begin
      if (cnt_q == LAST) begin
        cnt_n = '0;
        done  = 1'b1;
      end else begin
        cnt_n = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bus_reset && !bus_idle) |=> (cnt_q == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && bus_reset && !clr_all) |=> $stable(cnt_q));
  assert_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || clr_all) |=> (cnt_q == '0));
endmodule

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs
  import usb_pwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_down,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_read,
  input  logic             bus_reset,
  input  logic             idle_done,
  output logic             en_q,
  output logic             susp_q,
  output logic [REG_W-1:0] rd_data
);
  logic iso_q, res_q, rst_q;
  logic iso_n, res_n, en_n, susp_n, rst_n_val, susp_clr;

  always_comb begin
    iso_n     = iso_q;
    res_n     = res_q;
    en_n      = en_q;
    if (wr_en) begin
      iso_n = wr_data[BIT_ISO];
      res_n = wr_data[BIT_RES];
      en_n  = wr_data[BIT_EN];
    end
    susp_clr  = irq_read || res_n || !en_n;
    susp_n    = susp_clr ? 1'b0 : (susp_q || idle_done);
    rst_n_val = bus_reset;
    if (power_down) begin
      iso_n     = 1'b0;
      res_n     = 1'b0;
      en_n      = 1'b0;
      susp_n    = 1'b0;
      rst_n_val = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iso_q  <= 1'b0;
      res_q  <= 1'b0;
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      iso_q  <= iso_n;
      res_q  <= res_n;
      en_q   <= en_n;
      susp_q <= susp_n;
      rst_q  <= rst_n_val;
    end
  end

  always_comb begin
    rd_data           = '0;
    rd_data[BIT_EN]   = en_q;
    rd_data[BIT_SUSP] = susp_q;
    rd_data[BIT_RES]  = res_q;
    rd_data[BIT_RST]  = rst_q;
    rd_data[BIT_ISO]  = iso_q;
  end

  assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_read |=> !susp_q);
  assert_set_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(idle_done));
  assert_resume_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_q |-> !susp_q);
  assert_pdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |=> (rd_data == '0));
endmodule

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl
  import usb_pwr_pkg::*;
#(
  parameter int IDLE_US = 3000,
  parameter int TICK_US = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_idle,
  input  logic             bus_reset,
  input  logic             power_down,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_read,
  output logic [REG_W-1:0] read_data,
  output logic             resume_drive,
  output logic             suspended
);
  localparam int IDLE_TICKS = (IDLE_US / TICK_US) < 1 ? 1 : (IDLE_US / TICK_US);

  logic en_q, susp_q, idle_done;

  usb_idle_timer #(.IDLE_TICKS(IDLE_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (power_down),
    .en        (en_q),
    .bus_idle  (bus_idle),
    .bus_reset (bus_reset),
    .hold      (susp_q),
    .tick      (tick),
    .done      (idle_done)
  );

  usb_pwr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .power_down (power_down),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .irq_read   (irq_read),
    .bus_reset  (bus_reset),
    .idle_done  (idle_done),
    .en_q       (en_q),
    .susp_q     (susp_q),
    .rd_data    (read_data)
  );

  assign resume_drive = read_data[BIT_RES];
  assign suspended    = susp_q;

  assert_rst_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!power_down) |=> (read_data[BIT_RST] == $past(bus_reset)));
endmodule

// File: tb/sim_usb_pwr_ctl.sv
`timescale 1ns/1ps
module sim_usb_pwr_ctl;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, bus_idle = 1'b1, bus_reset = 1'b0, power_down = 1'b0;
  logic wr_en = 1'b0, irq_read = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] read_data;
  logic resume_drive, suspended;

  int n_chk = 0, n_fail = 0;
  logic m_en = 0, m_res = 0, m_iso = 0, m_susp = 0, m_rst = 0;
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  usb_pwr_ctl #(.IDLE_US(N), .TICK_US(1)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_idle(bus_idle),
    .bus_reset(bus_reset), .power_down(power_down), .wr_en(wr_en),
    .wr_data(wr_data), .irq_read(irq_read), .read_data(read_data),
    .resume_drive(resume_drive), .suspended(suspended)
  );

  function automatic logic [7:0] exp_reg();
    return {m_iso, 3'b000, m_rst, m_res, m_susp, m_en};
  endfunction

  // Reference model of the requirements, advanced at each rising edge
  always @(posedge clk) begin
    logic en_n, res_n, iso_n, done, clr;
    if (!rst_n) begin
      m_en = 0; m_res = 0; m_iso = 0; m_susp = 0; m_rst = 0; m_cnt = 0;
    end else if (power_down) begin
      m_en = 0; m_res = 0; m_iso = 0; m_susp = 0; m_rst = 0; m_cnt = 0;
    end else begin
      en_n = wr_en ? wr_data[0] : m_en;
      res_n = wr_en ? wr_data[2] : m_res;
      iso_n = wr_en ? wr_data[7] : m_iso;
      done = 0;
      if (!m_en) m_cnt = 0;
      else if (bus_reset) m_cnt = m_cnt;
      else if (!bus_idle) m_cnt = 0;
      else if (tick && !m_susp) begin
        if (m_cnt == N - 1) begin m_cnt = 0; done = 1; end
        else m_cnt = m_cnt + 1;
      end
      clr = irq_read || res_n || !en_n;
      m_susp = clr ? 1'b0 : (m_susp || done);
      m_en = en_n; m_res = res_n; m_iso = iso_n; m_rst = bus_reset;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Continuous comparison against the model, away from the rising edge
  logic model_on = 1'b0;
  always @(negedge clk) begin
    if (model_on) begin
      check("R2 read_data", read_data, exp_reg());
      check("R4 suspended", suspended, m_susp);
      check("R9 resume_drive", resume_drive, m_res);
    end
  end

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    idle_cyc(3);
    check("R1 read_data", read_data, 0);
    check("R1 suspended", suspended, 0);
    check("R1 resume_drive", resume_drive, 0);
    @(negedge clk); rst_n = 1'b1;
    model_on = 1'b1;
    idle_cyc(2);

    // R2: reserved and read-only bits ignore writes
    wr(8'hFB);
    check("R2 write FB", read_data, 8'h81);
    wr(8'h00);
    check("R2 write 00", read_data, 8'h00);

    // R4: exact threshold
    wr(8'h01);
    pulse_ticks(N - 1);
    check("R4 one tick short", suspended, 0);
    pulse_ticks(1);
    check("R4 at threshold", suspended, 1);
    check("R4 status bit", read_data, 8'h03);

    // R8: interrupt register read clears suspend
    @(negedge clk); irq_read = 1'b1;
    @(negedge clk); irq_read = 1'b0;
    check("R8 cleared by read", suspended, 0);

    // R5: activity restarts count
    pulse_ticks(N - 1);
    @(negedge clk); bus_idle = 1'b0;
    @(negedge clk); bus_idle = 1'b1;
    pulse_ticks(N - 1);
    check("R5 restarted", suspended, 0);
    pulse_ticks(1);
    check("R5 full run after restart", suspended, 1);
    @(negedge clk); irq_read = 1'b1;
    @(negedge clk); irq_read = 1'b0;

    // R6 / R3: bus reset freezes count and shows in bit 3
    pulse_ticks(N - 2);
    @(negedge clk); bus_reset = 1'b1; bus_idle = 1'b0;
    @(negedge clk);
    check("R3 reset visible", read_data[3], 1);
    pulse_ticks(5);
    @(negedge clk); bus_reset = 1'b0; bus_idle = 1'b1;
    @(negedge clk);
    check("R3 reset gone", read_data[3], 0);
    pulse_ticks(1);
    check("R6 held count", suspended, 0);
    pulse_ticks(1);
    check("R6 resumed count", suspended, 1);

    // R9: resume clears suspend and drives bus
    wr(8'h05);
    check("R9 resume_drive", resume_drive, 1);
    check("R9 suspend cleared", suspended, 0);
    pulse_ticks(N + 2);
    check("R9 no suspend while resume", suspended, 0);
    wr(8'h01);
    check("R9 resume released", resume_drive, 0);

    // R7: disabling discards count
    pulse_ticks(N - 2);
    wr(8'h00);
    wr(8'h01);
    pulse_ticks(N - 1);
    check("R7 count discarded", suspended, 0);
    pulse_ticks(1);
    check("R7 suspend after fresh run", suspended, 1);
    wr(8'h00);
    check("R7 disable clears suspend", suspended, 0);

    // R10: power down beats a write
    wr(8'h85);
    @(negedge clk); power_down = 1'b1; wr_en = 1'b1; wr_data = 8'h85;
    @(negedge clk); power_down = 1'b0; wr_en = 1'b0;
    check("R10 cleared", read_data, 8'h00);

    // Random phase against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      tick       = ($urandom % 3) == 0;
      bus_idle   = ($urandom % 256) != 0;
      if (($urandom % 256) == 0) bus_reset = ~bus_reset;
      power_down = ($urandom % 2048) == 0;
      irq_read   = ($urandom % 256) == 0;
      wr_en      = ($urandom % 128) == 0;
      wr_data    = {1'($urandom), 3'($urandom), 1'($urandom),
                    1'(($urandom % 8) == 0), 1'($urandom),
                    1'(($urandom % 8) != 0)};
    end
    @(negedge clk);
    tick = 0; wr_en = 0; irq_read = 0; power_down = 0; bus_reset = 0; bus_idle = 1;
    idle_cyc(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule